// File: doc/BRIEF.md
# Parallel Modulation Word Assembler

This block takes 16-bit modulation words from an external parallel port and turns them into full-width oscillator parameters: a 14-bit amplitude, a 16-bit phase offset and a 32-bit frequency. The port clock and the transmit-enable input are sampled in the block's own clock domain. A word is taken when the selected edge of the port clock is seen and transmit-enable is at its active level. A 2-bit route select decides which parameter or parameters the word updates.

Some targets need more bits than the port carries. In the polar route, the word supplies the upper bits of both amplitude and phase, and programmed low-order fields fill in the rest. In the frequency route, the word is shifted left by a 4-bit gain before it lands in the 32-bit parameter. A one-cycle strobe marks each capture.

When transmit-enable is inactive, port data has no effect. A control bit then chooses between keeping the last parameters and forcing the routed word to zero.

Top module: `pmod_assembler`

## Requirements
- R1: While `rst_n` is low at a clock edge, `amp_out`, `phase_out` and `freq_out` become zero and `out_valid` becomes 0.
- R2: With `route` = 2'b00 (amplitude), a capture loads `amp_out` with `pdata[15:2]`; `pdata[1:0]` have no effect.
- R3: With `route` = 2'b01 (phase), a capture loads `phase_out` with all 16 bits of `pdata`.
- R4: With `route` = 2'b10 (frequency), a capture loads `freq_out` with `pdata` zero-extended to 32 bits and shifted left by `fm_gain` (0 to 15), so its low `fm_gain` bits are zero.
- R5: With `route` = 2'b11 (polar), a capture loads `amp_out` with `{pdata[15:8], asf_lo[5:0]}` and `phase_out` with `{pdata[7:0], pow_lo[7:0]}`.
- R6: A capture happens on the clock edge where `pclk` is first seen high after being low when `pclk_inv` = 0, or first seen low after being high when `pclk_inv` = 1; the opposite transition captures nothing.
- R7: Transmit-enable is active when `tx_en` XOR `txen_inv` is 1, so `tx_en` is active-high by default and active-low when `txen_inv` = 1.
- R8: While transmit-enable is inactive, port edges and `pdata` have no effect. If `hold_last` = 1, every parameter holds its value. If `hold_last` = 0, the parameters of the current route are loaded as if the word were zero (polar then gives amplitude `asf_lo` and phase `pow_lo`).
- R9: `out_valid` is high for exactly the one cycle after each capture edge and is low otherwise.
- R10: A capture leaves every parameter that the current route does not target unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pclk | input | 1 | Port clock, sampled by clk |
| tx_en | input | 1 | Transmit-enable gate |
| pdata | input | 16 | Port data word |
| route | input | 2 | Destination select |
| pclk_inv | input | 1 | 0: capture on rising port edge, 1: on falling |
| txen_inv | input | 1 | Inverts the active level of tx_en |
| hold_last | input | 1 | 1: hold while disabled, 0: clear routed word |
| fm_gain | input | 4 | Left shift applied in frequency route |
| asf_lo | input | 6 | Amplitude low bits for polar route |
| pow_lo | input | 8 | Phase low bits for polar route |
| amp_out | output | 14 | Amplitude parameter |
| phase_out | output | 16 | Phase parameter |
| freq_out | output | 32 | Frequency parameter |
| out_valid | output | 1 | One-cycle capture strobe |

## Verification
The assertions assume that `pclk` and `tx_en` are already synchronous to `clk` and that a port-clock level lasts at least one clock cycle. They also assume that `route`, `fm_gain` and the polar low fields are steady at the edge where a capture is taken, because the checks relate each output to inputs from one cycle earlier. The stimulus changes all inputs only on the falling clock edge, holds each port-clock level for a full cycle, and sets the configuration before it raises the port clock.

// File: rtl/pmod_assembler.sv
module pmod_assembler #(
  parameter int DW = 16,
  parameter int AW = 14,
  parameter int PW = 16,
  parameter int FW = 32,
  parameter int GW = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 pclk,
  input  logic                 tx_en,
  input  logic [DW-1:0]        pdata,
  input  logic [1:0]           route,
  input  logic                 pclk_inv,
  input  logic                 txen_inv,
  input  logic                 hold_last,
  input  logic [GW-1:0]        fm_gain,
  input  logic [AW-DW/2-1:0]   asf_lo,
  input  logic [PW-DW/2-1:0]   pow_lo,
  output logic [AW-1:0]        amp_out,
  output logic [PW-1:0]        phase_out,
  output logic [FW-1:0]        freq_out,
  output logic                 out_valid
);
  localparam int HB = DW / 2;
  localparam logic [1:0] RT_AMP = 2'b00, RT_PHS = 2'b01, RT_FRQ = 2'b10, RT_POL = 2'b11;

  logic pclk_q;

  wire en_true = tx_en ^ txen_inv;
  wire edge_hit = pclk_inv ? (pclk_q & ~pclk) : (~pclk_q & pclk);
  wire cap = edge_hit & en_true;
  wire clr = ~en_true & ~hold_last;
  wire upd = cap | clr;
  wire [DW-1:0] word = cap ? pdata : '0;

  wire [AW-1:0] amp_nx = (route == RT_POL) ? {word[DW-1:HB], asf_lo} : word[DW-1:DW-AW];
  wire [PW-1:0] phs_nx = (route == RT_POL) ? {word[HB-1:0], pow_lo} : PW'(word);
  wire [FW-1:0] frq_nx = {{(FW-DW){1'b0}}, word} << fm_gain;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pclk_q    <= 1'b0;
      out_valid <= 1'b0;
      amp_out   <= '0;
      phase_out <= '0;
      freq_out  <= '0;
    end else begin
      pclk_q    <= pclk;
      out_valid <= cap;
      if (upd) begin
        case (route)
          RT_AMP: amp_out <= amp_nx;
          RT_PHS: phase_out <= phs_nx;
          RT_FRQ: freq_out <= frq_nx;
          RT_POL: begin
            amp_out   <= amp_nx;
            phase_out <= phs_nx;
          end
        endcase
      end
    end
  end

  p_reset_clears_r1: assert property (@(posedge clk)
    !rst_n |=> (amp_out == '0 && phase_out == '0 && freq_out == '0 && !out_valid));

  p_amp_map_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(route) == RT_AMP) |-> amp_out == $past(pdata[DW-1:DW-AW]));

  p_phase_map_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(route) == RT_PHS) |-> phase_out == PW'($past(pdata)));

  p_freq_low_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(route) == RT_FRQ) |->
      ((freq_out & ((FW'(1) << $past(fm_gain)) - FW'(1))) == '0 &&
       (freq_out >> $past(fm_gain)) == FW'($past(pdata))));

  p_polar_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(route) == RT_POL) |->
      (amp_out[AW-HB-1:0] == $past(asf_lo) && phase_out[PW-HB-1:0] == $past(pow_lo)));

  p_valid_needs_enable_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(tx_en ^ txen_inv));

  p_hold_when_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!(tx_en ^ txen_inv) && hold_last) |=>
      ($stable(amp_out) && $stable(phase_out) && $stable(freq_out) && !out_valid));

  p_valid_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid || $past(pclk) != pclk_q);
endmodule

// File: tb/pmod_assembler_bench.sv
module pmod_assembler_bench;
  logic clk = 1'b0, rst_n = 1'b0, pclk = 1'b0, tx_en = 1'b1;
  logic [15:0] pdata = '0;
  logic [1:0] route = '0;
  logic pclk_inv = 1'b0, txen_inv = 1'b0, hold_last = 1'b0;
  logic [3:0] fm_gain = '0;
  logic [5:0] asf_lo = 6'h2A;
  logic [7:0] pow_lo = 8'h5C;
  logic [13:0] amp_out;
  logic [15:0] phase_out;
  logic [31:0] freq_out;
  logic out_valid;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  pmod_assembler u_pmod_assembler (
    .clk, .rst_n, .pclk, .tx_en, .pdata, .route, .pclk_inv, .txen_inv,
    .hold_last, .fm_gain, .asf_lo, .pow_lo, .amp_out, .phase_out,
    .freq_out, .out_valid);

  typedef struct packed { logic [1:0] rt; logic [3:0] g; logic [15:0] d; logic [31:0] e; } vec_t;
  localparam vec_t VECS [10] = '{
    '{2'b00, 4'd0,  16'hABCD, 32'h0000_2AF3},
    '{2'b00, 4'd0,  16'hFFFF, 32'h0000_3FFF},
    '{2'b00, 4'd0,  16'h0003, 32'h0000_0000},
    '{2'b01, 4'd0,  16'h1234, 32'h0000_1234},
    '{2'b01, 4'd0,  16'hFFFF, 32'h0000_FFFF},
    '{2'b10, 4'd0,  16'hBEEF, 32'h0000_BEEF},
    '{2'b10, 4'd4,  16'hBEEF, 32'h000B_EEF0},
    '{2'b10, 4'd15, 16'hFFFF, 32'h7FFF_8000},
    '{2'b11, 4'd0,  16'hA53C, 32'h296A_3C5C},
    '{2'b11, 4'd0,  16'h0000, 32'h002A_005C}};

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] pick(input logic [1:0] rt);
    case (rt)
      2'b00: return {18'd0, amp_out};
      2'b01: return {16'd0, phase_out};
      2'b10: return freq_out;
      default: return {2'b00, amp_out, phase_out};
    endcase
  endfunction

  task automatic toggle(input logic lvl);
    @(negedge clk) pclk = lvl;
    @(negedge clk);
  endtask

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset", {amp_out, phase_out, out_valid}, 0);
    chk("R1 reset freq", freq_out, 0);
    rst_n = 1'b1;
    @(negedge clk);
    foreach (VECS[i]) begin
      route = VECS[i].rt; fm_gain = VECS[i].g; pdata = VECS[i].d;
      toggle(1'b1);
      chk($sformatf("R2-5 vec%0d value", i), pick(VECS[i].rt), VECS[i].e);
      chk("R9 strobe high", out_valid, 1);
      toggle(1'b0);
      chk("R9 strobe low", out_valid, 0);
    end
    chk("R10 freq untouched by polar", freq_out, 32'h7FFF_8000);

    route = 2'b00; pdata = 16'h8888; pclk_inv = 1'b1;
    toggle(1'b1);
    chk("R6 rising ignored when inverted", out_valid, 0);
    chk("R6 amp unchanged", amp_out, 14'h002A);
    toggle(1'b0);
    chk("R6 falling captures", amp_out, 14'h2222);
    pclk_inv = 1'b0;

    hold_last = 1'b1; tx_en = 1'b0; pdata = 16'h4444;
    toggle(1'b1);
    chk("R8 data ignored while off", amp_out, 14'h2222);
    chk("R7 no strobe while off", out_valid, 0);
    toggle(1'b0);

    txen_inv = 1'b1;
    toggle(1'b1);
    chk("R7 inverted level captures", amp_out, 14'h1111);
    toggle(1'b0);
    txen_inv = 1'b0;

    hold_last = 1'b0; tx_en = 1'b0;
    @(negedge clk);
    chk("R8 clear amp route", amp_out, 0);
    chk("R8 phase kept", phase_out, 16'h005C);
    route = 2'b11; asf_lo = 6'h15; pow_lo = 8'hC3;
    @(negedge clk);
    chk("R8 clear polar", {amp_out, phase_out}, {14'h0015, 16'h00C3});
    tx_en = 1'b1;

    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 mid-run reset", {amp_out, phase_out, freq_out}, 0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule